// File: doc/BRIEF.md
# Autonegotiation Result Validity Monitor

This block sits beside an Ethernet PHY's autonegotiation logic and judges each completed negotiation before the link is used. Whenever negotiation is enabled and the done indication rises, the monitor looks at three inputs in the same cycle:

- the received partner-ability word;
- the expansion register;
- a status bit from a hidden register bank that signals a healthy exchange.

If any of these shows a known corruption signature, the monitor emits a one-cycle restart strobe so that the negotiation engine starts over. Otherwise it raises a result-valid flag.

Retries are counted. After a bounded number of consecutive restarts, the monitor stops retrying and raises a sticky failure flag, which only a reset clears. A passing check clears the retry count.

The monitor re-evaluates only on a fresh rising edge of done. A done level that stays high never triggers a second check, so each negotiation attempt is judged exactly once.

Top module: `aneg_guard`

## Requirements
- R1: After reset, restartPulse, resultValid and failFlag are all 0.
- R2: A check happens only in the cycle where anegDone rises while anegEnable is 1. A rise with anegEnable at 0 changes no output.
- R3: A check fails when hiddenOk is 0 at the rising edge of done.
- R4: A check fails when expansion bit 0 (the partner can negotiate) is 1 and partnerAbility bit 14 (acknowledge) is 0. When expansion bit 0 is 0, a missing acknowledge alone does not fail the check.
- R5: A check fails when partnerAbility equals exactly 16'h0001, whatever the expansion register holds.
- R6: A passing check sets resultValid in the cycle after the rising edge of done. resultValid stays 1 while done stays high and returns to 0 one cycle after done goes low.
- R7: A failing check issues restartPulse for exactly one cycle, in the cycle after the rising edge of done. A done level held high issues no further pulse.
- R8: Up to 6 consecutive failing checks each issue a restart. The 7th consecutive failure issues no pulse and sets failFlag instead.
- R9: failFlag is sticky until reset. While it is set, no restart pulse is issued and resultValid stays 0.
- R10: A passing check clears the retry count, so a further 6 failures are each retried again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| anegEnable | input | 1 | Autonegotiation is enabled |
| anegDone | input | 1 | Negotiation-complete indication |
| partnerAbility | input | 16 | Received partner-ability word |
| expansion | input | 16 | Autonegotiation expansion register |
| hiddenOk | input | 1 | Hidden-bank health bit; 1 means the exchange was sound |
| restartPulse | output | 1 | One-cycle request to restart negotiation |
| resultValid | output | 1 | The current negotiation result is trusted |
| failFlag | output | 1 | Sticky flag: the retry limit is exhausted |

## Verification
A wrong retry count shows at the ports only at the end of a run of failures. The failure flag then appears one attempt early or one attempt late, or a 7th pulse comes out where none is expected. The bench therefore drives full runs of failures, both with and without an intervening pass.

A stale done-edge register shows within one cycle of a done rise, as a missing pulse or a doubled pulse. Each attempt holds done high for several cycles and checks that the pulse ends after one cycle.

A valid flag that fails to clear is visible one cycle after done falls.

// File: rtl/aneg_guard_pkg.sv
package aneg_guard_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic incRetry;
    logic clrRetry;
  } ctlStrobe_t;
endpackage

// File: rtl/aneg_guard_dp.sv
module aneg_guard_dp
  import aneg_guard_pkg::*;
#(
  parameter int WORD_W      = 16,
  parameter int RETRY_LIMIT = 6,
  parameter int ACK_POS     = 14,
  parameter int NWAY_POS    = 0,
  parameter bit EARLY_CHECK = 1'b1,
  parameter logic [WORD_W-1:0] EARLY_CODE = WORD_W'(1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              anegEnable,
  input  logic              anegDone,
  input  logic [WORD_W-1:0] partnerAbility,
  input  logic [WORD_W-1:0] expansion,
  input  logic              hiddenOk,
  input  ctlStrobe_t        strobe,
  output logic              checkEvt,
  output logic              resultBad,
  output logic              retryAtMax
);
  localparam int CNT_W = $clog2(RETRY_LIMIT + 1);

  logic             doneQ;
  logic [CNT_W-1:0] retryCnt;
  logic             ackMissing;
  logic             earlyHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) doneQ <= 1'b0;
    else       doneQ <= anegDone;
  end

  assign checkEvt = anegEnable & anegDone & ~doneQ;

  assign ackMissing = expansion[NWAY_POS] & ~partnerAbility[ACK_POS];

  generate
    if (EARLY_CHECK) begin : g_early
      assign earlyHit = (partnerAbility == EARLY_CODE);
    end else begin : g_noEarly
      assign earlyHit = 1'b0;
    end
  endgenerate

  assign resultBad = ~hiddenOk | ackMissing | earlyHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                retryCnt <= '0;
    else if (strobe.clrRetry) retryCnt <= '0;
    else if (strobe.incRetry) retryCnt <= retryCnt + CNT_W'(1);
  end

  assign retryAtMax = (retryCnt == CNT_W'(RETRY_LIMIT));
endmodule

// File: rtl/aneg_guard_ctl.sv
module aneg_guard_ctl
  import aneg_guard_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       anegDone,
  input  logic       checkEvt,
  input  logic       resultBad,
  input  logic       retryAtMax,
  output ctlStrobe_t strobe,
  output logic       restartPulse,
  output logic       resultValid,
  output logic       failFlag
);
  logic liveEvt;

  assign liveEvt = checkEvt & ~failFlag;

  always_comb begin
    strobe = '0;
    strobe.incRetry = liveEvt & resultBad & ~retryAtMax;
    strobe.clrRetry = liveEvt & ~resultBad;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      restartPulse <= 1'b0;
      resultValid  <= 1'b0;
      failFlag     <= 1'b0;
    end else begin
      restartPulse <= liveEvt & resultBad & ~retryAtMax;
      failFlag     <= failFlag | (liveEvt & resultBad & retryAtMax);
      if (!anegDone || failFlag)        resultValid <= 1'b0;
      else if (liveEvt && !resultBad)   resultValid <= 1'b1;
    end
  end
endmodule

// File: rtl/aneg_guard.sv
module aneg_guard
  import aneg_guard_pkg::*;
#(
  parameter int WORD_W      = 16,
  parameter int RETRY_LIMIT = 6,
  parameter int ACK_POS     = 14,
  parameter int NWAY_POS    = 0,
  parameter bit EARLY_CHECK = 1'b1,
  parameter logic [WORD_W-1:0] EARLY_CODE = WORD_W'(1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              anegEnable,
  input  logic              anegDone,
  input  logic [WORD_W-1:0] partnerAbility,
  input  logic [WORD_W-1:0] expansion,
  input  logic              hiddenOk,
  output logic              restartPulse,
  output logic              resultValid,
  output logic              failFlag
);
  ctlStrobe_t strobe;
  logic checkEvt, resultBad, retryAtMax;

  aneg_guard_dp #(
    .WORD_W(WORD_W), .RETRY_LIMIT(RETRY_LIMIT), .ACK_POS(ACK_POS),
    .NWAY_POS(NWAY_POS), .EARLY_CHECK(EARLY_CHECK), .EARLY_CODE(EARLY_CODE)
  ) u_dp (
    .clk(clk), .rstN(rstN), .anegEnable(anegEnable), .anegDone(anegDone),
    .partnerAbility(partnerAbility), .expansion(expansion), .hiddenOk(hiddenOk),
    .strobe(strobe), .checkEvt(checkEvt), .resultBad(resultBad),
    .retryAtMax(retryAtMax)
  );

  aneg_guard_ctl u_ctl (
    .clk(clk), .rstN(rstN), .anegDone(anegDone), .checkEvt(checkEvt),
    .resultBad(resultBad), .retryAtMax(retryAtMax), .strobe(strobe),
    .restartPulse(restartPulse), .resultValid(resultValid), .failFlag(failFlag)
  );
endmodule

// File: rtl/aneg_guard_chk.sv
module aneg_guard_chk (
  input logic clk,
  input logic rstN,
  input logic anegDone,
  input logic restartPulse,
  input logic resultValid,
  input logic failFlag
);
  // R7
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    restartPulse |=> !restartPulse);

  // R7
  pulse_after_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    restartPulse |-> $past(anegDone));

  // R9
  fail_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    failFlag |=> failFlag);

  // R9
  fail_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    failFlag |=> (!restartPulse && !resultValid));

  // R6
  valid_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    !anegDone |=> !resultValid);

  // R6
  valid_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(resultValid && restartPulse));
endmodule

bind aneg_guard aneg_guard_chk u_chk (
  .clk(clk), .rstN(rstN), .anegDone(anegDone),
  .restartPulse(restartPulse), .resultValid(resultValid), .failFlag(failFlag)
);

// File: tb/sim_aneg_guard.sv
module sim_aneg_guard;
  localparam int PERIOD = 10;

  typedef struct packed {
    logic restart;
    logic valid;
    logic fail;
  } expItem_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        anegEnable = 1'b0;
  logic        anegDone = 1'b0;
  logic [15:0] partnerAbility = '0;
  logic [15:0] expansion = '0;
  logic        hiddenOk = 1'b0;
  logic        restartPulse, resultValid, failFlag;

  int checks = 0;
  int errors = 0;
  int modelRetries = 0;
  bit modelFail = 1'b0;
  bit finished = 1'b0;
  expItem_t expQ[$];
  string    tagQ[$];

  always #(PERIOD/2) clk = ~clk;

  aneg_guard u0 (
    .clk(clk), .rstN(rstN), .anegEnable(anegEnable), .anegDone(anegDone),
    .partnerAbility(partnerAbility), .expansion(expansion), .hiddenOk(hiddenOk),
    .restartPulse(restartPulse), .resultValid(resultValid), .failFlag(failFlag)
  );

  task automatic check3(string tag, expItem_t got, expItem_t exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s restart/valid/fail got %b expected %b", tag, got, exp);
    end
  endtask

  // Monitor: compares the outputs against queued expectations after each edge
  always @(posedge clk) begin
    #1;
    if (expQ.size() > 0) begin
      expItem_t e;
      string t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      check3(t, {restartPulse, resultValid, failFlag}, e);
    end
  end

  // Driver: one negotiation attempt, with the expected outcome from the model
  task automatic attempt(string tag, logic en, logic hid, logic [15:0] lpa,
                         logic [15:0] exr);
    bit bad;
    expItem_t e;
    bad = !hid || (exr[0] && !lpa[14]) || (lpa == 16'h0001);
    e = '0;
    if (en && !modelFail) begin
      if (!bad) begin
        e.valid = 1'b1;
        modelRetries = 0;
      end else if (modelRetries < 6) begin
        e.restart = 1'b1;
        modelRetries++;
      end else begin
        modelFail = 1'b1;
      end
    end
    e.fail = modelFail;
    @(negedge clk);
    anegEnable = en; hiddenOk = hid; partnerAbility = lpa; expansion = exr;
    anegDone = 1'b1;
    expQ.push_back(e);
    tagQ.push_back(tag);
    @(negedge clk);
    @(negedge clk);
    // R7: done still high, the pulse is gone and no new one is issued
    check3({tag, " R7 hold"}, {restartPulse, resultValid, failFlag},
           {1'b0, e.valid, e.fail});
    anegDone = 1'b0;
    @(negedge clk);
    // R6: valid cleared one cycle after done falls
    check3({tag, " R6 drop"}, {restartPulse, resultValid, failFlag},
           {1'b0, 1'b0, e.fail});
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check3("R1 reset", {restartPulse, resultValid, failFlag}, 3'b000);
    rstN = 1'b1;
    @(negedge clk);
    check3("R1 after release", {restartPulse, resultValid, failFlag}, 3'b000);

    attempt("R2 disabled", 1'b0, 1'b0, 16'h0001, 16'h0001);
    attempt("R3 hidden clear", 1'b1, 1'b0, 16'h45E1, 16'h0001);
    attempt("R4 ack missing", 1'b1, 1'b1, 16'h05E1, 16'h0001);
    attempt("R5 early code", 1'b1, 1'b1, 16'h0001, 16'h0000);
    attempt("R6 pass", 1'b1, 1'b1, 16'h45E1, 16'h0001);
    attempt("R4 no nway pass", 1'b1, 1'b1, 16'h05E1, 16'h0000);
    // R10: five failures, a pass, then a full run of six
    for (int i = 0; i < 5; i++) attempt("R10 pre", 1'b1, 1'b0, 16'h45E1, 16'h0);
    attempt("R10 clear", 1'b1, 1'b1, 16'h45E1, 16'h0001);
    for (int i = 0; i < 6; i++) attempt("R8 retry", 1'b1, 1'b0, 16'h45E1, 16'h0);
    attempt("R8 exhaust", 1'b1, 1'b0, 16'h45E1, 16'h0);
    attempt("R9 sticky pass", 1'b1, 1'b1, 16'h45E1, 16'h0001);
    attempt("R9 sticky bad", 1'b1, 1'b0, 16'h45E1, 16'h0001);

    repeat (2) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(PERIOD * 20000);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule